// File: doc/BRIEF.md
# Signed Adder with Carry and Corrected Status Flags

This block adds two 8-bit two's-complement operands and a one-bit carry input in a single pass. Alongside the 8-bit result it reports four flags. The first is the unsigned carry out of the top bit. The second is a signed overflow indication. The third is a sign flag that describes the true mathematical result, so it is inverted when the 8-bit sum has wrapped. The fourth is a zero flag that is withheld whenever the wrapped sum does not represent the real result.

The carry input enters the adder through an extra low-order bit position that is appended to both operands. The carry out is taken from an extra high-order position. One adder therefore serves both purposes, with no separate incrementer. The block is purely combinational. It is meant to sit inside an arithmetic datapath that chains narrow additions, or that needs flags for conditional decisions.

Top module: `sadd_flags`

## Requirements
- R1: `sum` equals (a + b + cin) modulo 256, with a and b taken as unsigned 8-bit values.
- R2: `cout` equals bit 8 of the 9-bit unsigned total a + b + cin.
- R3: `overflow` is 1 exactly when bit 7 of a and bit 7 of b are equal and bit 7 of `sum` differs from them.
- R4: `overflow` is 0 whenever bit 7 of a differs from bit 7 of b.
- R5: `sign` is 1 exactly when the signed total (a and b read as two's complement, plus cin) is negative. This equals bit 7 of `sum` when `overflow` is 0, and its inverse when `overflow` is 1.
- R6: `zero` is 1 exactly when `overflow` is 0 and `sum` is 0x00. In particular, 0x80 + 0x80 with cin = 0 gives `zero` = 0.
- R7: A carry input of 1 adds exactly one to the total. For the same a and b, the 9-bit value {cout, sum} with cin = 1 is one greater, modulo 512, than with cin = 0. This also holds where cin alone causes overflow (0x7F + 0x00 + 1 gives sum 0x80, overflow 1, sign 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | First operand, two's complement |
| b | input | 8 | Second operand, two's complement |
| cin | input | 1 | Carry input, weight one |
| sum | output | 8 | Low 8 bits of a + b + cin |
| cout | output | 1 | Unsigned carry out of bit 7 |
| zero | output | 1 | Sum is zero and no overflow occurred |
| overflow | output | 1 | Signed overflow of the addition |
| sign | output | 1 | Sign of the true signed result |

## Verification
The checker's immediate assertions assume that every input is a known 0 or 1. They are skipped while any input or output carries X or Z, which covers the time before the bench first drives the inputs. The stimulus always drives all three inputs together on the falling clock edge, so that they settle well before any sampling point. It sweeps every combination of a, b and cin, so the inputs are never left undriven once the sweep begins.

// File: rtl/sadd_flags_pkg.sv
package sadd_flags_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned EXT_W  = DATA_W + 2;

    typedef struct packed {
        logic cout;
        logic zero;
        logic ovf;
        logic neg;
    } flags_t;

endpackage

// File: rtl/sadd_pad_adder.sv
module sadd_pad_adder #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         c_in,
    output logic [W-1:0] total,
    output logic         c_out
);
    localparam int unsigned XW = W + 2;

    logic [XW-1:0] pad_a_d;
    logic [XW-1:0] pad_b_d;
    logic [XW-1:0] wide_d;

    // Low guard bit: constant 1 on one side, carry on the other.
    // Their sum carries into bit 1 exactly when c_in is 1.
    always_comb begin
        pad_a_d = {1'b0, op_a, 1'b1};
        pad_b_d = {1'b0, op_b, c_in};
        wide_d  = pad_a_d + pad_b_d;
        total   = wide_d[W:1];
        c_out   = wide_d[XW-1];
    end
endmodule

// File: rtl/sadd_status.sv
module sadd_status #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]           op_a,
    input  logic [W-1:0]           op_b,
    input  logic [W-1:0]           total,
    input  logic                   c_out,
    output sadd_flags_pkg::flags_t flags
);
    logic sgn_a_d;
    logic sgn_b_d;
    logic sgn_s_d;
    logic all_clear_d;

    always_comb begin
        sgn_a_d     = op_a[W-1];
        sgn_b_d     = op_b[W-1];
        sgn_s_d     = total[W-1];
        all_clear_d = ~|total;

        flags.cout = c_out;
        flags.ovf  = (sgn_a_d & sgn_b_d & ~sgn_s_d) |
                     (~sgn_a_d & ~sgn_b_d & sgn_s_d);
        // Wrapped result: its MSB is the wrong sign and a zero pattern is false.
        flags.neg  = sgn_s_d ^ flags.ovf;
        flags.zero = all_clear_d & ~flags.ovf;
    end
endmodule

// File: rtl/sadd_flags.sv
module sadd_flags
    import sadd_flags_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              zero,
    output logic              overflow,
    output logic              sign
);
    logic [DATA_W-1:0] total_d;
    logic              carry_d;
    flags_t            flags_d;

    sadd_pad_adder #(.W(DATA_W)) adder_i (
        .op_a  (a),
        .op_b  (b),
        .c_in  (cin),
        .total (total_d),
        .c_out (carry_d)
    );

    sadd_status #(.W(DATA_W)) status_i (
        .op_a  (a),
        .op_b  (b),
        .total (total_d),
        .c_out (carry_d),
        .flags (flags_d)
    );

    always_comb begin
        sum      = total_d;
        cout     = flags_d.cout;
        zero     = flags_d.zero;
        overflow = flags_d.ovf;
        sign     = flags_d.neg;
    end
endmodule

// File: rtl/sadd_flags_chk.sv
module sadd_flags_chk
    import sadd_flags_pkg::*;
(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic              cin,
    input logic [DATA_W-1:0] sum,
    input logic              cout,
    input logic              zero,
    input logic              overflow,
    input logic              sign
);
    logic [DATA_W:0] full_d;
    logic            known_d;

    always_comb begin
        full_d  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        known_d = !$isunknown({a, b, cin, sum, cout, zero, overflow, sign});
        if (known_d) begin
            AST_SUM_VALUE: assert ({cout, sum} == full_d);                       // R1
            AST_MIXED_SIGNS: assert (!(a[DATA_W-1] != b[DATA_W-1] && overflow));  // R4
            AST_OVF_SIGNS: assert (!overflow || (a[DATA_W-1] == b[DATA_W-1] &&
                                                 sum[DATA_W-1] != a[DATA_W-1])); // R3
            AST_TRUE_SIGN: assert (!overflow || (sign == a[DATA_W-1]));          // R5
            AST_NO_FALSE_ZERO: assert (!(zero && (overflow || sum != '0)));      // R6
        end
    end
endmodule

bind sadd_flags sadd_flags_chk chk_i (
    .a        (a),
    .b        (b),
    .cin      (cin),
    .sum      (sum),
    .cout     (cout),
    .zero     (zero),
    .overflow (overflow),
    .sign     (sign)
);

// File: tb/sadd_flags_tb_top.sv
`timescale 1ns/1ps
module sadd_flags_tb_top;
    logic       clk = 1'b0;
    logic [7:0] a, b;
    logic       cin;
    logic [7:0] sum;
    logic       cout, zero, overflow, sign;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    sadd_flags dut_i (
        .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
        .zero(zero), .overflow(overflow), .sign(sign)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s a=%02h b=%02h cin=%0d actual=%0d expected=%0d",
                     req, a, b, cin, act, exp_v);
        end
    endtask

    // Behavioural reference from integer arithmetic.
    task automatic apply(input int av, input int bv, input int cv);
        int sa, sb, st, ut, e_sum, e_cout, e_ovf, e_neg, e_zero;
        @(negedge clk);
        a = av[7:0]; b = bv[7:0]; cin = cv[0];
        @(posedge clk);
        #1;
        sa = (av > 127) ? av - 256 : av;
        sb = (bv > 127) ? bv - 256 : bv;
        st = sa + sb + cv;
        ut = av + bv + cv;
        e_sum  = ut % 256;
        e_cout = ut / 256;
        e_ovf  = (st > 127 || st < -128) ? 1 : 0;
        e_neg  = (st < 0) ? 1 : 0;
        e_zero = (e_ovf == 0 && e_sum == 0) ? 1 : 0;
        chk("R1", int'(sum), e_sum);
        chk("R2", int'(cout), e_cout);
        chk("R3", int'(overflow), e_ovf);
        if ((av >= 128) != (bv >= 128)) chk("R4", int'(overflow), 0);
        chk("R5", int'(sign), e_neg);
        chk("R6", int'(zero), e_zero);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
            finish_up();
        end
    end

    initial begin
        int lo0, lo1;
        a = '0; b = '0; cin = 1'b0;
        // Idle state: all-zero inputs give a true zero.
        apply(0, 0, 0);
        chk("R6", int'(zero), 1);
        // Corner cases named in the requirements.
        apply(8'h80, 8'h80, 0);            // R6: wrapped zero suppressed
        chk("R6", int'(zero), 0);
        chk("R5", int'(sign), 1);
        apply(8'h7F, 8'h01, 0);            // R3 positive overflow
        chk("R3", int'(overflow), 1);
        chk("R5", int'(sign), 0);
        apply(8'h7F, 8'h00, 1);            // R7: carry alone overflows
        chk("R7", int'(sum), 8'h80);
        chk("R7", int'(overflow), 1);
        apply(8'hFF, 8'h00, 1);            // R2 carry out, true zero
        chk("R2", int'(cout), 1);
        chk("R6", int'(zero), 1);
        apply(8'h80, 8'h7F, 1);            // R4 mixed signs
        chk("R4", int'(overflow), 0);
        // R7: carry adds exactly one.
        apply(8'hA5, 8'h3C, 0);
        lo0 = {cout, sum};
        apply(8'hA5, 8'h3C, 1);
        lo1 = {cout, sum};
        chk("R7", lo1, (lo0 + 1) % 512);
        apply(8'hFF, 8'hFF, 0);
        lo0 = {cout, sum};
        apply(8'hFF, 8'hFF, 1);
        lo1 = {cout, sum};
        chk("R7", lo1, (lo0 + 1) % 512);
        // Exhaustive sweep.
        for (int i = 0; i < 256; i++)
            for (int j = 0; j < 256; j++)
                for (int c = 0; c < 2; c++)
                    apply(i, j, c);
        finish_up();
    end
endmodule